// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial frames on an input line that idles high. A one-cycle sample strobe arrives at sixteen times the bit rate from outside the block. Each strobe is one sample point. The receiver locks onto each falling start edge by itself, independently of any transmitter timing. It confirms the start edge with three extra samples. It then takes three samples near the middle of every bit and decides the bit value by a two-out-of-three vote. Data arrives least significant bit first, in either an 8-bit or a 9-bit format.

A completed word is presented on a valid/ready output. `out_valid` rises together with the data and two status flags: `noise_flag` and `frame_err`. All of them hold until a cycle in which `out_ready` is high, and that cycle clears `out_valid` and both flags together. The serial line cannot be paused, so the receiver never stalls on back-pressure. If a new frame completes before the old word has been taken, the new word and its flags replace the old ones.

Recovery after a bad stop bit depends on the frame. After an ordinary framing error, the receiver acts as if a stop bit had arrived and expects the next start bit exactly one bit period later, even if the line never returned high. After a break (an all-zero frame), the receiver waits for the line to go high before it looks for a new start edge.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, `out_valid`, `noise_flag` and `frame_err` are 0 and `out_data` is 0x00.
- R2: While idle, a low sample that follows a high sample begins a frame, and that low sample counts as sample 1 of the start bit. A line that stays high produces no output.
- R3: Samples 3, 5 and 7 of the start bit confirm the start. If fewer than two of them are low, the frame is dropped and nothing is presented.
- R4: Every bit value is the majority of its samples 8, 9 and 10. One deviating sample among the three does not change the value.
- R5: `noise_flag` is set for a presented frame when the three mid samples of any start, data or stop bit disagree, or when an accepted start had confirmation samples that disagree. A frame with no such disagreement presents `noise_flag` = 0.
- R6: A frame is one start bit (0), the data bits least significant first, and one stop bit. With `nine_bit` = 0 there are 8 data bits, delivered on `out_data[7:0]`.
- R7: With `nine_bit` = 1 there are 9 data bits. The ninth bit received appears on `out_ninth`. In 8-bit format `out_ninth` is 0.
- R8: A stop bit that votes 0 presents the word with `frame_err` = 1 and `out_valid` = 1.
- R9: A break is a frame whose voted start, data and stop bits are all 0. It presents `out_valid` = 1, `frame_err` = 1 and `out_data` = 0x00. Afterwards, no new frame begins until the line has been sampled high.
- R10: After a framing error that is not a break, the sample that follows the 16th sample of the stop bit is taken as a start-edge candidate, as if the line had been high just before it.
- R11: `out_valid`, `out_data`, `out_ninth` and both flags hold while `out_ready` is 0. A cycle with `out_valid` and `out_ready` both high clears `out_valid`, `noise_flag` and `frame_err`. A newly completed frame overwrites whatever is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle sample strobe at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| nine_bit | input | 1 | Format select: 0 for 8 data bits, 1 for 9; captured at each start edge |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_valid | output | 1 | A received word is presented |
| out_data | output | 8 | Lower 8 data bits of the received word |
| out_ninth | output | 1 | Ninth data bit in 9-bit format, otherwise 0 |
| noise_flag | output | 1 | Sample disagreement seen within the presented frame |
| frame_err | output | 1 | Stop bit of the presented frame voted 0 |

## Verification
The bench goes after the following corner cases:

- **Start-edge filtering.** A short low pulse that fails confirmation must be dropped. A design that trusted the first low sample would present a spurious word.
- **Single-sample disturbances.** One wrong sample placed inside the mid-bit window of a data bit, of the stop bit, or of the start-confirmation window must leave the word intact and set the noise flag. Voting on the wrong samples, or losing the flag, shows up as wrong data, a false framing error or a clear `noise_flag`.
- **Framing-error recovery.** An ordinary framing error followed at once by a new start on a line that never went high must still deliver the second word. A design lacking the artificial start would miss that word.
- **Break recovery.** A long low after a break must not start a frame. A design that treated a break like an ordinary framing error would present an extra all-zero word.
- **Handshake.** Holding and overwrite are checked at `out_valid`, `out_data` and the flags.

// File: rtl/uart_vote_pkg.sv
`timescale 1ns/1ps
package uart_vote_pkg;
  // receiver sequencing: waiting for an edge, inside a frame, or sitting out
  // the rest of a failed stop bit before forcing the next start slot
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HOLD = 2'd2
  } rx_state_e;
endpackage

// File: rtl/uart_vote_maj3.sv
`timescale 1ns/1ps
module uart_vote_maj3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y,
  output logic mixed
);
  always_comb begin
    y     = (a & b) | (a & c) | (b & c);
    mixed = ~((a == b) && (b == c));
  end
endmodule

// File: rtl/uart_vote_seq.sv
`timescale 1ns/1ps
module uart_vote_seq
  import uart_vote_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rxd,
  input  logic        nine_mode,
  output logic        done,
  output logic [DW:0] word,
  output logic        noisy,
  output logic        ferr,
  output logic        busy
);
  localparam int RT_W = $clog2(OVS + 1);
  localparam int BP_W = $clog2(DW + 3);
  localparam logic [RT_W-1:0] RT_ONE  = RT_W'(1);
  localparam logic [RT_W-1:0] RT_TWO  = RT_W'(2);
  localparam logic [RT_W-1:0] RT_LAST = RT_W'(OVS);
  localparam logic [RT_W-1:0] MID_A   = RT_W'(OVS / 2);
  localparam logic [RT_W-1:0] MID_B   = RT_W'(OVS / 2 + 1);
  localparam logic [RT_W-1:0] MID_C   = RT_W'(OVS / 2 + 2);
  localparam logic [RT_W-1:0] VER_A   = RT_W'(OVS / 2 - 5);
  localparam logic [RT_W-1:0] VER_B   = RT_W'(OVS / 2 - 3);
  localparam logic [RT_W-1:0] VER_C   = RT_W'(OVS / 2 - 1);
  localparam logic [BP_W-1:0] STOP8   = BP_W'(DW + 1);
  localparam logic [BP_W-1:0] STOP9   = BP_W'(DW + 2);

  rx_state_e       state;
  logic [RT_W-1:0] rt;       // index of the sample taken at the next strobe
  logic [BP_W-1:0] bitpos;   // 0 = start, then data, then stop
  logic [1:0]      vlow;     // low confirmation samples so far
  logic            acc;      // disagreement seen in this frame
  logic            prev;     // last idle sample (forced on recovery)
  logic            nine_q;
  logic            s_a, s_b;
  logic            mid_bit, mid_mixed;
  logic [1:0]      v_tot;
  logic [BP_W-1:0] stop_pos;
  logic            brk;

  uart_vote_maj3 u_vote (.a(s_a), .b(s_b), .c(rxd), .y(mid_bit), .mixed(mid_mixed));

  always_comb begin
    v_tot    = vlow + {1'b0, ~rxd};
    stop_pos = nine_q ? STOP9 : STOP8;
    brk      = ~mid_bit && (word == '0);
    busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rt     <= RT_ONE;
      bitpos <= '0;
      vlow   <= '0;
      acc    <= 1'b0;
      prev   <= 1'b0;
      nine_q <= 1'b0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      word   <= '0;
      done   <= 1'b0;
      noisy  <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            prev <= rxd;
            if (prev && !rxd) begin
              state  <= ST_RECV;
              rt     <= RT_TWO;
              bitpos <= '0;
              vlow   <= '0;
              acc    <= 1'b0;
              word   <= '0;
              nine_q <= nine_mode;
            end
          end
          ST_RECV: begin
            rt <= (rt == RT_LAST) ? RT_ONE : rt + 1'b1;
            if (rt == RT_LAST) bitpos <= bitpos + 1'b1;
            if (bitpos == '0 && (rt == VER_A || rt == VER_B))
              vlow <= v_tot;
            if (bitpos == '0 && rt == VER_C) begin
              if (v_tot < 2'd2) begin
                state <= ST_IDLE;
                prev  <= rxd;
              end else if (v_tot != 2'd3) begin
                acc <= 1'b1;
              end
            end
            if (rt == MID_A) s_a <= rxd;
            if (rt == MID_B) s_b <= rxd;
            if (rt == MID_C) begin
              if (mid_mixed) acc <= 1'b1;
              if (bitpos != '0 && bitpos != stop_pos)
                word[bitpos - 1'b1] <= mid_bit;
              if (bitpos == stop_pos) begin
                done  <= 1'b1;
                noisy <= acc | mid_mixed;
                ferr  <= ~mid_bit;
                if (mid_bit) begin
                  state <= ST_IDLE;
                  prev  <= rxd;
                end else if (brk) begin
                  state <= ST_IDLE;
                  prev  <= 1'b0;
                end else begin
                  state <= ST_HOLD;
                end
              end
            end
          end
          ST_HOLD: begin
            rt <= rt + 1'b1;
            if (rt == RT_LAST) begin
              state <= ST_IDLE;
              prev  <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_vote_hold.sv
`timescale 1ns/1ps
module uart_vote_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW:0]   word,
  input  logic          noisy,
  input  logic          ferr,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          extra,
  output logic          noise_f,
  output logic          ferr_f
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      extra   <= 1'b0;
      noise_f <= 1'b0;
      ferr_f  <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      data    <= word[DW-1:0];
      extra   <= word[DW];
      noise_f <= noisy;
      ferr_f  <= ferr;
    end else if (valid && take) begin
      valid   <= 1'b0;
      noise_f <= 1'b0;
      ferr_f  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_vote_rx.sv
`timescale 1ns/1ps
module uart_vote_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          nine_bit,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_ninth,
  output logic          noise_flag,
  output logic          frame_err
);
  logic        frame_done;
  logic [DW:0] frame_word;
  logic        frame_noisy;
  logic        frame_ferr;
  logic        busy;

  uart_vote_seq #(.OVS(OVS), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd), .nine_mode(nine_bit),
    .done(frame_done), .word(frame_word), .noisy(frame_noisy),
    .ferr(frame_ferr), .busy(busy)
  );

  uart_vote_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(frame_done), .word(frame_word),
    .noisy(frame_noisy), .ferr(frame_ferr), .take(out_ready),
    .valid(out_valid), .data(out_data), .extra(out_ninth),
    .noise_f(noise_flag), .ferr_f(frame_err)
  );
endmodule

// File: rtl/uart_vote_rx_chk.sv
`timescale 1ns/1ps
module uart_vote_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          noise_flag,
  input logic          frame_err,
  input logic          frame_done,
  input logic          busy
);
  assert_flags_need_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_flag || frame_err) |-> out_valid);

  assert_take_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_done) |=> (!out_valid && !noise_flag && !frame_err));

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_done) |=>
      (out_valid && $stable(out_data) && $stable(noise_flag) && $stable(frame_err)));

  assert_done_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(busy));

  assert_valid_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_done));
endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .noise_flag(noise_flag), .frame_err(frame_err),
  .frame_done(frame_done), .busy(busy)
);

// File: tb/sim_uart_vote_rx.sv
`timescale 1ns/1ps
module sim_uart_vote_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       nine_bit = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_ninth, noise_flag, frame_err;
  logic [7:0] out_data;
  logic [2:0] tcnt = 3'd0;
  logic       tick16;
  int         tests = 0;
  int         fails = 0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) tcnt <= tcnt + 3'd1;
  assign tick16 = (tcnt == 3'd7);

  uart_vote_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .nine_bit(nine_bit),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ninth(out_ninth), .noise_flag(noise_flag), .frame_err(frame_err)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // one sample point: hold the level across exactly one strobe
  task automatic one_sample(input logic v);
    rxd = v;
    do @(negedge clk); while (!tick16);
    @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic v, input int flip);
    for (int s = 1; s <= 16; s++) one_sample((s == flip) ? ~v : v);
  endtask

  task automatic idle_line(input logic v, input int n);
    for (int i = 0; i < n; i++) one_sample(v);
  endtask

  task automatic send_frame(input logic [8:0] w, input bit nine9, input logic stopv,
                            input int fbit, input int fpos);
    int nb;
    nb = nine9 ? 9 : 8;
    send_bit(1'b0, (fbit == 0) ? fpos : 0);
    for (int i = 0; i < nb; i++) send_bit(w[i], (fbit == i + 1) ? fpos : 0);
    send_bit(stopv, (fbit == nb + 1) ? fpos : 0);
  endtask

  task automatic take_word();
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "valid", 16'(out_valid), 16'h0);
    check("R1", "noise", 16'(noise_flag), 16'h0);
    check("R1", "ferr", 16'(frame_err), 16'h0);
    check("R1", "data", 16'(out_data), 16'h00);
  endtask

  task automatic t_idle_and_glitch();
    idle_line(1'b1, 40);
    check("R2", "valid on idle line", 16'(out_valid), 16'h0);
    one_sample(1'b0);
    one_sample(1'b0);
    idle_line(1'b1, 200);
    check("R3", "valid after short low", 16'(out_valid), 16'h0);
  endtask

  task automatic t_clean_and_hold();
    send_frame(9'h0A5, 1'b0, 1'b1, -1, 0);
    check("R6", "valid", 16'(out_valid), 16'h1);
    check("R6", "data", 16'(out_data), 16'hA5);
    check("R7", "ninth in 8-bit", 16'(out_ninth), 16'h0);
    check("R5", "noise clean", 16'(noise_flag), 16'h0);
    check("R8", "ferr clean", 16'(frame_err), 16'h0);
    idle_line(1'b1, 20);
    check("R11", "still valid", 16'(out_valid), 16'h1);
    check("R11", "data held", 16'(out_data), 16'hA5);
    take_word();
    check("R11", "valid after take", 16'(out_valid), 16'h0);
  endtask

  task automatic t_noise();
    send_frame(9'h03C, 1'b0, 1'b1, 3, 9);
    check("R4", "data with glitched bit", 16'(out_data), 16'h3C);
    check("R5", "noise data bit", 16'(noise_flag), 16'h1);
    take_word();
    check("R11", "noise cleared", 16'(noise_flag), 16'h0);
    send_frame(9'h096, 1'b0, 1'b1, 9, 10);
    check("R4", "stop glitch no ferr", 16'(frame_err), 16'h0);
    check("R5", "noise stop bit", 16'(noise_flag), 16'h1);
    check("R4", "data", 16'(out_data), 16'h96);
    take_word();
    send_frame(9'h071, 1'b0, 1'b1, 0, 5);
    check("R3", "start with one high confirm", 16'(out_data), 16'h71);
    check("R5", "noise from confirm", 16'(noise_flag), 16'h1);
    take_word();
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send_frame(9'h15A, 1'b1, 1'b1, -1, 0);
    check("R7", "data 9-bit", 16'(out_data), 16'h5A);
    check("R7", "ninth bit", 16'(out_ninth), 16'h1);
    check("R7", "ferr 9-bit", 16'(frame_err), 16'h0);
    take_word();
    nine_bit = 1'b0;
  endtask

  task automatic t_ferr_recover();
    send_frame(9'h081, 1'b0, 1'b0, -1, 0);
    check("R8", "valid", 16'(out_valid), 16'h1);
    check("R8", "ferr", 16'(frame_err), 16'h1);
    check("R8", "data", 16'(out_data), 16'h81);
    take_word();
    send_frame(9'h042, 1'b0, 1'b1, -1, 0);
    check("R10", "valid after forced start", 16'(out_valid), 16'h1);
    check("R10", "data after forced start", 16'(out_data), 16'h42);
    check("R10", "ferr after forced start", 16'(frame_err), 16'h0);
    take_word();
    idle_line(1'b1, 8);
  endtask

  task automatic t_break();
    send_frame(9'h000, 1'b0, 1'b0, -1, 0);
    check("R9", "valid", 16'(out_valid), 16'h1);
    check("R9", "ferr", 16'(frame_err), 16'h1);
    check("R9", "data", 16'(out_data), 16'h00);
    take_word();
    idle_line(1'b0, 160);
    idle_line(1'b1, 20);
    check("R9", "no frame while low after break", 16'(out_valid), 16'h0);
    send_frame(9'h05E, 1'b0, 1'b1, -1, 0);
    check("R9", "data after line high", 16'(out_data), 16'h5E);
    check("R9", "valid after line high", 16'(out_valid), 16'h1);
    take_word();
  endtask

  task automatic t_overwrite();
    send_frame(9'h011, 1'b0, 1'b1, -1, 0);
    send_frame(9'h022, 1'b0, 1'b1, -1, 0);
    check("R11", "overwrite valid", 16'(out_valid), 16'h1);
    check("R11", "overwrite data", 16'(out_data), 16'h22);
    take_word();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_idle_and_glitch();
    t_clean_and_hold();
    t_noise();
    t_nine();
    t_ferr_recover();
    t_break();
    t_overwrite();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule